// File: doc/BRIEF.md
# Cascadable Dual 8-bit Interval Timer

Two 8-bit up-counters, each paired with an 8-bit compare register, produce periodic interrupt pulses from prescaler tick strobes. A two-bit mode field sets how the pair works. The two halves can run as separate timers. The upper half can count once per lower-half match. The two halves can also be joined into one 16-bit interval timer. In 16-bit mode the lower compare register supplies the low byte of the period and the upper compare register supplies the high byte. The lower half's carry advances the upper half, whatever tick select is programmed for the upper half.

A simple write port loads three registers: the lower compare register, the upper compare register and a control register. Writing the lower compare register suspends all compare matching. Matching resumes once the upper compare register is written, so software writes the low byte first and a 16-bit period is never half updated. Counting happens on one-cycle enable strobes in the system clock domain, never on derived clocks.

Top module: `casc_interval_timer`

## Requirements
- R1: Synchronous reset clears both counters, both compare registers and the control register, and leaves matching enabled. After reset no interrupt pulses occur until a run bit is set. Running the lower half with the reset compare value of 0 gives a match on every tick.
- R2: The lower counter advances on `tick_in[sel_lo]`, where sel_lo is control bits [3:2]. When its count equals the lower compare value C on a tick, it clears to zero and `irq_lo` is high for the following cycle. The period is C+1 ticks.
- R3: In split mode (control bits [1:0] = 00 or 11), the upper counter advances on `tick_in[sel_hi]`, where sel_hi is control bits [5:4]. It behaves like the lower half and pulses `irq_hi`, with a period of upper compare + 1 ticks.
- R4: In chained mode (bits [1:0] = 01), the upper counter advances once per lower match. `irq_hi` therefore repeats every (lower compare + 1) × (upper compare + 1) lower ticks and coincides with an `irq_lo` pulse. sel_hi has no effect.
- R5: In 16-bit mode (bits [1:0] = 10), the lower counter's carry advances the upper counter and sel_hi is ignored. A match needs all 16 bits to equal {upper compare, lower compare}. The match clears both counters and pulses `irq_hi` only. The period is that 16-bit value + 1 lower ticks, and `irq_lo` stays low.
- R6: A write to address 0 (lower compare) disables matching in every mode. A write to address 1 (upper compare) re-enables it. While matching is disabled, counters wrap past all-ones and no interrupt pulse occurs. Address 2 holds the control register.
- R7: While a half's run bit is clear, its counter is held at zero and it produces no pulse. The run bits are bit 6 for the lower half and bit 7 for the upper half. After the lower run bit is written to 1 with a tick on every cycle and compare C, the first `irq_lo` is seen C+2 cycles after the cycle in which the write is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 lower compare, 1 upper compare, 2 control, 3 unused |
| wr_data | input | CW | Write data |
| tick_in | input | NTICK | Prescaler tick strobes, one cycle each |
| irq_lo | output | 1 | Lower-half match pulse |
| irq_hi | output | 1 | Upper-half / 16-bit match pulse |

## Verification
The assertions take for granted that every `tick_in` bit is a strobe generated in the `clk` domain. They also assume that mode and run bits change only through the control register. The bench gives each tick line a strobe once every 2^i cycles and changes each configuration only while both halves are stopped, with the compares written low byte first. It then measures the distance between the second and third pulse, so the partial first period after a restart never enters an expected value.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  typedef enum logic [1:0] {
    IVT_SPLIT  = 2'b00,
    IVT_CHAIN  = 2'b01,
    IVT_WIDE   = 2'b10,
    IVT_SPLIT2 = 2'b11
  } ivt_mode_e;

  typedef struct packed {
    logic      run_hi;
    logic      run_lo;
    logic [1:0] sel_hi;
    logic [1:0] sel_lo;
    ivt_mode_e mode;
  } ivt_ctrl_t;

  localparam logic [1:0] IVT_A_CMPLO = 2'd0;
  localparam logic [1:0] IVT_A_CMPHI = 2'd1;
  localparam logic [1:0] IVT_A_CTRL  = 2'd2;

endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] cmp_lo,
  output logic [CW-1:0] cmp_hi,
  output ivt_ctrl_t     ctrl,
  output logic          cmp_en
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_lo <= '0;
      cmp_hi <= '0;
      ctrl   <= '0;
      cmp_en <= 1'b1;
    end else if (wr_en) begin
      case (wr_addr)
        IVT_A_CMPLO: begin
          cmp_lo <= wr_data;
          cmp_en <= 1'b0;
        end
        IVT_A_CMPHI: begin
          cmp_hi <= wr_data;
          cmp_en <= 1'b1;
        end
        IVT_A_CTRL: ctrl <= ivt_ctrl_t'(wr_data[7:0]);
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ivt_tick_sel.sv
module ivt_tick_sel #(
  parameter int NTICK = 4,
  localparam int SELW = (NTICK > 1) ? $clog2(NTICK) : 1
) (
  input  logic [NTICK-1:0] tick_in,
  input  logic [SELW-1:0]  sel,
  output logic             tick
);

  always_comb tick = tick_in[sel];

endmodule

// File: rtl/ivt_half.sv
module ivt_half #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tick,
  input  logic          clr,
  output logic [CW-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= clr ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/casc_interval_timer.sv
module casc_interval_timer
  import ivt_pkg::*;
#(
  parameter int CW    = 8,
  parameter int NTICK = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CW-1:0]    wr_data,
  input  logic [NTICK-1:0] tick_in,
  output logic             irq_lo,
  output logic             irq_hi
);

  logic [CW-1:0] cmp_lo, cmp_hi, cnt_lo, cnt_hi;
  ivt_ctrl_t     ctrl;
  logic          cmp_en;
  logic          tick_lo, tick_hs, tick_hi;
  logic          wide, chain, go_lo, go_hi;
  logic          eq_lo, eq_hi, carry_lo;
  logic          evt_lo, evt_hi, evt_wide;

  ivt_regs #(.CW(CW)) u_regs (
    .clk, .rst, .wr_en, .wr_addr, .wr_data,
    .cmp_lo, .cmp_hi, .ctrl, .cmp_en
  );

  ivt_tick_sel #(.NTICK(NTICK)) u_sel_lo (
    .tick_in, .sel(ctrl.sel_lo), .tick(tick_lo)
  );

  ivt_tick_sel #(.NTICK(NTICK)) u_sel_hi (
    .tick_in, .sel(ctrl.sel_hi), .tick(tick_hs)
  );

  always_comb begin
    wide     = (ctrl.mode == IVT_WIDE);
    chain    = (ctrl.mode == IVT_CHAIN);
    eq_lo    = (cnt_lo == cmp_lo);
    eq_hi    = (cnt_hi == cmp_hi);
    go_lo    = tick_lo && ctrl.run_lo;
    carry_lo = go_lo && (cnt_lo == '1);
    evt_lo   = go_lo && eq_lo && cmp_en && !wide;
    evt_wide = go_lo && eq_lo && eq_hi && cmp_en && wide;
    tick_hi  = wide ? carry_lo : (chain ? evt_lo : tick_hs);
    go_hi    = tick_hi && ctrl.run_hi;
    evt_hi   = go_hi && eq_hi && cmp_en && !wide;
  end

  ivt_half #(.CW(CW)) u_lo (
    .clk, .rst, .run(ctrl.run_lo), .tick(tick_lo),
    .clr(evt_lo || evt_wide), .cnt(cnt_lo)
  );

  ivt_half #(.CW(CW)) u_hi (
    .clk, .rst, .run(ctrl.run_hi), .tick(tick_hi || evt_wide),
    .clr(evt_hi || evt_wide), .cnt(cnt_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
    end else begin
      irq_lo <= evt_lo;
      irq_hi <= evt_hi || evt_wide;
    end
  end

  AST_LO_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    irq_lo |-> $past(tick_lo)); // R2
  AST_LO_CLEARED: assert property (@(posedge clk) disable iff (rst)
    irq_lo |-> (cnt_lo == '0)); // R2
  AST_HI_CLEARED: assert property (@(posedge clk) disable iff (rst)
    irq_hi |-> (cnt_hi == '0)); // R3
  AST_CHAIN_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (irq_hi && $past(ctrl.mode) == IVT_CHAIN) |-> irq_lo); // R4
  AST_WIDE_LO_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ctrl.mode == IVT_WIDE) |=> !irq_lo); // R5
  AST_WIDE_BOTH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (irq_hi && $past(ctrl.mode) == IVT_WIDE) |-> (cnt_lo == '0)); // R5
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    !cmp_en |=> (!irq_lo && !irq_hi)); // R6
  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ctrl.run_lo |=> !irq_lo); // R7

endmodule

// File: tb/sim_casc_interval_timer.sv
module sim_casc_interval_timer;

  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic [3:0] tick_in;
  logic       irq_lo, irq_hi;
  int         cyc;
  int         n_chk = 0;
  int         n_fail = 0;

  always #2 clk = ~clk;

  casc_interval_timer u0 (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .tick_in, .irq_lo, .irq_hi
  );

  // tick_in[i] strobes once every 2^i cycles
  initial begin
    cyc = 0;
    tick_in = 4'b1111;
  end
  always @(negedge clk) begin
    cyc = cyc + 1;
    for (int i = 0; i < 4; i++) tick_in[i] = ((cyc & ((1 << i) - 1)) == 0);
  end

  // vector table: control, lower compare, upper compare, expected lo/hi period in cycles
  localparam int NV = 6;
  localparam int V_CTRL [NV] = '{8'hD0, 8'hC8, 8'hF1, 8'hC5, 8'hF2, 8'hC6};
  localparam int V_CL   [NV] = '{5,     0,     5,     3,     8'h23, 8'hFF};
  localparam int V_CH   [NV] = '{2,     9,     2,     4,     8'h01, 8'h00};
  localparam int V_PLO  [NV] = '{6,     4,     6,     8,     0,     0};
  localparam int V_PHI  [NV] = '{6,     10,    18,    40,    292,   512};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // distance in cycles between the 2nd and 3rd high samples; -1 on timeout
  task automatic period(input bit hi, output int d, output int lo_hits);
    int n = 0, k = 0, t2 = 0;
    d = -1; lo_hits = 0;
    while (n < 6000) begin
      @(negedge clk);
      n++;
      if (irq_lo) lo_hits++;
      if (hi ? irq_hi : irq_lo) begin
        k++;
        if (k == 2) t2 = n;
        if (k == 3) begin d = n - t2; break; end
      end
    end
  endtask

  task automatic quiet(input int cycles, output int hits);
    hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (irq_lo || irq_hi) hits++;
    end
  endtask

  function automatic string hi_req(input int ctrl);
    case (ctrl & 3)
      1: return "R4";
      2: return "R5";
      default: return "R3";
    endcase
  endfunction

  initial begin
    #(4 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int d, lh, h, n;
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: quiet after reset, compares zero and matching enabled
    quiet(20, h);
    chk("R1 no pulse after reset", h, 0);
    wr(2'd2, 8'h40);
    period(1'b0, d, lh);
    chk("R1 reset compare 0 matches every tick", d, 1);

    // table of modes
    for (int v = 0; v < NV; v++) begin
      wr(2'd2, 8'h00);
      wr(2'd0, 8'(V_CL[v]));
      wr(2'd1, 8'(V_CH[v]));
      wr(2'd2, 8'(V_CTRL[v]));
      if (V_PLO[v] != 0) begin
        period(1'b0, d, lh);
        chk($sformatf("R2 vector %0d irq_lo period", v), d, V_PLO[v]);
        period(1'b1, d, lh);
        chk($sformatf("%s vector %0d irq_hi period", hi_req(V_CTRL[v]), v), d, V_PHI[v]);
      end else begin
        period(1'b1, d, lh);
        chk($sformatf("R5 vector %0d 16-bit period", v), d, V_PHI[v]);
        chk($sformatf("R5 vector %0d irq_lo silent", v), lh, 0);
      end
    end

    // R6: lower compare write suspends matching until upper write
    wr(2'd2, 8'h00);
    wr(2'd0, 8'd3);
    wr(2'd2, 8'h40);
    quiet(600, h);
    chk("R6 no match while held off", h, 0);
    wr(2'd1, 8'd0);
    period(1'b0, d, lh);
    chk("R6 matching resumes after upper write", d, 4);

    // R7: stopped half stays silent, restart latency C+2
    wr(2'd2, 8'h00);
    quiet(20, h);
    chk("R7 stopped half silent", h, 0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h40;
    n = 0;
    while (n < 50) begin
      @(negedge clk);
      wr_en = 1'b0;
      n++;
      if (irq_lo) break;
    end
    chk("R7 first pulse after run", n, 5);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule